// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block sits beside an SDRAM command bus and only listens. Every clock it decodes the chip select, row strobe, column strobe, write enable, bank select and auto-precharge address bit. From them it keeps a model of each bank and of the device-wide state, and it flags any command that the current state does not allow. Each flag comes with a code that gives the kind of violation. The state model appears as a vector of per-bank codes, so a system bench can follow it or log it.

Every timing window is a parameter counted in clock edges. A timed state of length N entered at edge k is reported in the output cycles after edges k to k+N-2. The state that follows is reported from the cycle after edge k+N-1, so a command sampled at edge k+N is judged against the following state. Outputs change only at the rising clock edge: `err_valid` and `err_code` describe the command sampled at the edge just before, and `bank_state` gives the state against which the next edge will judge commands.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset, every bank reports idle and no error is flagged. Bank state codes are: 0 idle, 1 row activating, 2 row active, 3 read, 4 write, 5 read with auto precharge, 6 write with auto precharge, 7 precharging. Bank b occupies `bank_state[3b+2:3b]`.
- R2: A legal activate moves an idle bank into row activating, which lasts T_RCD edges and then becomes row active.
- R3: A legal read or write with the auto-precharge bit low puts the bank in read or write for BURST_LEN edges, after which it is row active again.
- R4: A legal read or write with the auto-precharge bit high puts the bank in the matching auto-precharge state for BURST_LEN+T_RP edges, after which it is idle. A later burst to another bank does not cut this state short.
- R5: A precharge to an open bank (row active, read or write) starts precharging for T_RP edges, ending idle. A precharge to an idle bank is legal and has no effect. An idle bank leaves idle only through an activate.
- R6: Any activate, read, write or single-bank precharge aimed at a bank that is activating, precharging or in an auto-precharge burst is flagged with code 1.
- R7: An activate to a non-idle bank, or a read or write to a bank that is idle, is flagged with code 2.
- R8: Auto refresh and mode-register load are legal only when every bank is idle; otherwise they are flagged with code 2. When legal, they start a device-wide window of T_RC and T_MRD edges respectively.
- R9: During a device-wide window (refresh, mode-register load, precharge-all), every command other than no-operation or inhibit is flagged with code 3. A command at the edge after the window closes is judged normally.
- R10: Burst terminate returns the bank holding the most recent burst to row active if that burst is a plain read or write, and it never changes any other bank.
- R11: A legal read or write to one bank returns any other bank that is in a plain read or write to row active.
- R12: An error is flagged for exactly the output cycle after the offending edge, with `err_code` 0 whenever `err_valid` is low, and a flagged command changes no tracked state.
- R13: Precharge-all is flagged with code 2 if any bank is activating, precharging or in an auto-precharge burst. Otherwise it puts every non-idle bank into precharging and opens a device-wide window of T_RP edges.
- R14: Commands decode from {cs_n, ras_n, cas_n, we_n}: 1xxx inhibit, 0111 no-operation, 0011 activate, 0101 read, 0100 write, 0110 burst terminate, 0010 precharge (precharge-all when a10 is high), 0001 auto refresh, 0000 mode-register load. An inhibit is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BW | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| bank_state | output | 3*NUM_BANKS | Per-bank state codes |
| err_valid | output | 1 | One-cycle violation flag |
| err_code | output | 2 | 1 protected interrupt, 2 wrong state, 3 device-wide window |

## Verification
The embedded properties check a few rules on every cycle: an idle bank stays idle unless it is activated, a legal activate is followed by the activating state, and a command issued inside a device-wide window is flagged with code 3. A refresh issued while a bank is open is always flagged, and every error pulse traces back to a real command. The exact lengths of each timed state, which bank a terminate acts on, how one bank's burst cuts another's, and the boundary edges where a window closes are shown only by the bench's scripted command sequences. Those sequences compare the whole state vector after each edge.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BW-1:0]          ba,
  input  logic                   a10,
  output logic [3*NUM_BANKS-1:0] bank_state,
  output logic                   err_valid,
  output logic [1:0]             err_code
);

  localparam int T_BAP = BURST_LEN + T_RP;
  localparam int M1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M2 = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M3 > T_BAP) ? M3 : T_BAP;
  localparam int CW = $clog2(TMAX + 1);

  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD - 1);
  localparam logic [CW-1:0] L_BL  = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] L_BAP = CW'(T_BAP - 1);

  localparam logic [1:0] E_NONE = 2'd0, E_PROT = 2'd1, E_STATE = 2'd2, E_GLOB = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ACTG, S_ACT, S_RD, S_WR, S_RDA, S_WRA, S_PRE} bst_t;
  typedef enum logic [1:0] {G_RUN, G_REF, G_MRS, G_PALL} gst_t;
  typedef enum logic [3:0] {C_NOP, C_ACT, C_RD, C_WR, C_BST, C_PRE, C_PALL, C_REF, C_LMR} cmd_t;

  bst_t          st_q  [NUM_BANKS];
  bst_t          st_d  [NUM_BANKS];
  bst_t          eff   [NUM_BANKS];
  logic [CW-1:0] cnt_q [NUM_BANKS];
  logic [CW-1:0] cnt_d [NUM_BANKS];
  gst_t          g_q, g_d, g_eff;
  logic [CW-1:0] gcnt_q, gcnt_d;
  logic [BW-1:0] last_q, last_d;
  cmd_t          cmd;
  bst_t          tgt;
  logic          any_prot, all_idle;
  logic [1:0]    err_c;

  function automatic logic is_prot(bst_t s);
    return s inside {S_ACTG, S_RDA, S_WRA, S_PRE};
  endfunction

  always_comb begin
    if (cs_n) cmd = C_NOP;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = a10 ? C_PALL : C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_LMR;
        default: cmd = C_NOP;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      unique case (st_q[b])
        S_ACTG:             eff[b] = (cnt_q[b] == '0) ? S_ACT  : S_ACTG;
        S_RD, S_WR:         eff[b] = (cnt_q[b] == '0) ? S_ACT  : st_q[b];
        S_RDA, S_WRA, S_PRE: eff[b] = (cnt_q[b] == '0) ? S_IDLE : st_q[b];
        default:            eff[b] = st_q[b];
      endcase
    end
  end

  assign g_eff = (gcnt_q == '0) ? G_RUN : g_q;
  assign tgt   = eff[ba];

  always_comb begin
    any_prot = 1'b0;
    all_idle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (is_prot(eff[b])) any_prot = 1'b1;
      if (eff[b] != S_IDLE) all_idle = 1'b0;
    end
  end

  always_comb begin
    err_c = E_NONE;
    if (cmd != C_NOP) begin
      if (g_eff != G_RUN) err_c = E_GLOB;
      else begin
        unique case (cmd)
          C_ACT:        err_c = is_prot(tgt) ? E_PROT : (tgt != S_IDLE) ? E_STATE : E_NONE;
          C_RD, C_WR:   err_c = is_prot(tgt) ? E_PROT :
                                (tgt inside {S_ACT, S_RD, S_WR}) ? E_NONE : E_STATE;
          C_PRE:        err_c = is_prot(tgt) ? E_PROT : E_NONE;
          C_PALL:       err_c = any_prot ? E_STATE : E_NONE;
          C_REF, C_LMR: err_c = all_idle ? E_NONE : E_STATE;
          default:      err_c = E_NONE;
        endcase
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      st_d[b]  = eff[b];
      cnt_d[b] = (cnt_q[b] == '0) ? '0 : cnt_q[b] - 1'b1;
    end
    g_d    = g_eff;
    gcnt_d = (gcnt_q == '0) ? '0 : gcnt_q - 1'b1;
    last_d = last_q;
    if (err_c == E_NONE) begin
      unique case (cmd)
        C_ACT: begin
          st_d[ba]  = S_ACTG;
          cnt_d[ba] = L_RCD;
        end
        C_RD, C_WR: begin
          for (int b = 0; b < NUM_BANKS; b++)
            if (b != int'(ba) && eff[b] inside {S_RD, S_WR}) st_d[b] = S_ACT;
          if (cmd == C_RD) st_d[ba] = a10 ? S_RDA : S_RD;
          else             st_d[ba] = a10 ? S_WRA : S_WR;
          cnt_d[ba] = a10 ? L_BAP : L_BL;
          last_d    = ba;
        end
        C_BST: if (eff[last_q] inside {S_RD, S_WR}) st_d[last_q] = S_ACT;
        C_PRE: if (tgt != S_IDLE) begin
          st_d[ba]  = S_PRE;
          cnt_d[ba] = L_RP;
        end
        C_PALL: begin
          for (int b = 0; b < NUM_BANKS; b++)
            if (eff[b] != S_IDLE) begin
              st_d[b]  = S_PRE;
              cnt_d[b] = L_RP;
            end
          g_d    = G_PALL;
          gcnt_d = L_RP;
        end
        C_REF: begin
          g_d    = G_REF;
          gcnt_d = L_RC;
        end
        C_LMR: begin
          g_d    = G_MRS;
          gcnt_d = L_MRD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        st_q[b]  <= S_IDLE;
        cnt_q[b] <= '0;
      end
      g_q       <= G_RUN;
      gcnt_q    <= '0;
      last_q    <= '0;
      err_valid <= 1'b0;
      err_code  <= E_NONE;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        st_q[b]  <= st_d[b];
        cnt_q[b] <= cnt_d[b];
      end
      g_q       <= g_d;
      gcnt_q    <= gcnt_d;
      last_q    <= last_d;
      err_valid <= (err_c != E_NONE);
      err_code  <= err_c;
    end
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    assign bank_state[3*gb +: 3] = eff[gb];

    p_idle_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eff[gb] == S_IDLE && !(cmd == C_ACT && ba == BW'(gb))) |=> (eff[gb] == S_IDLE));

    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_ACT && ba == BW'(gb) && err_c == E_NONE)
        |=> (eff[gb] == ((T_RCD > 1) ? S_ACTG : S_ACT)));
  end

  p_window_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (g_eff != G_RUN && cmd != C_NOP) |=> (err_valid && err_code == E_GLOB));

  p_refresh_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (g_eff == G_RUN && cmd == C_REF && !all_idle) |=> (err_valid && err_code == E_STATE));

  p_err_has_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(cmd != C_NOP));

  p_code_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |-> (err_code == E_NONE));

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
  localparam int NB = 4;

  localparam logic [3:0] K_INH = 4'b1000, K_NOP = 4'b0111, K_ACT = 4'b0011,
                         K_RD  = 4'b0101, K_WR  = 4'b0100, K_BST = 4'b0110,
                         K_PRE = 4'b0010, K_REF = 4'b0001, K_LMR = 4'b0000;

  typedef struct {
    logic [1:0]  code;
    logic [11:0] st;
    string       req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0]  ba = '0;
  logic [11:0] bank_state;
  logic        err_valid;
  logic [1:0]  err_code;

  int total = 0, bad = 0;
  bit finished = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(.NUM_BANKS(NB), .T_RCD(3), .T_RP(3), .T_RC(7), .T_MRD(2), .BURST_LEN(4))
    u_sdram_cmd_monitor (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .bank_state(bank_state), .err_valid(err_valid),
      .err_code(err_code));

  function automatic logic [11:0] sv(int b3, int b2, int b1, int b0);
    return {3'(b3), 3'(b2), 3'(b1), 3'(b0)};
  endfunction

  task automatic check(string req, logic [1:0] code, logic [11:0] st);
    total++;
    if (err_valid !== (code != 2'd0) || err_code !== code || bank_state !== st) begin
      bad++;
      $display("FAIL %s: got err=%0b code=%0d state=%h, expected err=%0b code=%0d state=%h",
               req, err_valid, err_code, bank_state, code != 2'd0, code, st);
    end
  endtask

  task automatic step(logic [3:0] k, int bank, logic ap, logic [1:0] code, logic [11:0] st, string req);
    item_t it;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = k;
    ba  = 2'(bank);
    a10 = ap;
    it.code = code; it.st = st; it.req = req;
    q.push_back(it);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.req, it.code, it.st);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", 2'd0, sv(0,0,0,0));
    step(K_ACT, 0, 0, 0, sv(0,0,0,1), "R2 activate");
    step(K_NOP, 0, 0, 0, sv(0,0,0,1), "R2 activating holds");
    step(K_ACT, 0, 0, 1, sv(0,0,0,2), "R6 activate during activating");
    step(K_RD,  0, 0, 0, sv(0,0,0,3), "R3 read");
    step(K_NOP, 0, 0, 0, sv(0,0,0,3), "R3 read holds");
    step(K_NOP, 0, 0, 0, sv(0,0,0,3), "R3 read holds");
    step(K_NOP, 0, 0, 0, sv(0,0,0,2), "R3 read ends");
    step(K_WR,  1, 0, 2, sv(0,0,0,2), "R7 write to idle bank");
    step(K_ACT, 1, 0, 0, sv(0,0,1,2), "R12 error lasts one cycle");
    step(K_RD,  0, 0, 0, sv(0,0,1,3), "R3 read bank0");
    step(K_NOP, 0, 0, 0, sv(0,0,2,3), "R2 activating ends");
    step(K_WR,  1, 0, 0, sv(0,0,4,2), "R11 write cuts other read");
    step(K_BST, 3, 0, 0, sv(0,0,2,2), "R10 terminate latest burst");
    step(K_RD,  1, 1, 0, sv(0,0,5,2), "R4 read with auto precharge");
    step(K_PRE, 1, 0, 1, sv(0,0,5,2), "R6 precharge during auto precharge");
    step(K_RD,  0, 0, 0, sv(0,0,5,3), "R4 auto precharge not cut");
    step(K_BST, 1, 0, 0, sv(0,0,5,2), "R10 terminate leaves other bank");
    step(K_NOP, 0, 0, 0, sv(0,0,5,2), "R4 holds");
    step(K_NOP, 0, 0, 0, sv(0,0,5,2), "R4 holds");
    step(K_NOP, 0, 0, 0, sv(0,0,0,2), "R4 ends idle");
    step(K_PRE, 0, 0, 0, sv(0,0,0,7), "R5 precharge");
    step(K_NOP, 0, 0, 0, sv(0,0,0,7), "R5 precharging holds");
    step(K_NOP, 0, 0, 0, sv(0,0,0,0), "R5 precharge ends");
    step(K_PRE, 2, 0, 0, sv(0,0,0,0), "R5 precharge idle bank");
    step(K_REF, 0, 0, 0, sv(0,0,0,0), "R8 refresh all idle");
    step(K_ACT, 3, 0, 3, sv(0,0,0,0), "R9 activate in refresh");
    step(K_INH & 4'b1000, 0, 0, 0, sv(0,0,0,0), "R14 inhibit in refresh");
    step(K_NOP, 0, 0, 0, sv(0,0,0,0), "R9 window");
    step(K_NOP, 0, 0, 0, sv(0,0,0,0), "R9 window");
    step(K_NOP, 0, 0, 0, sv(0,0,0,0), "R9 window");
    step(K_ACT, 3, 0, 3, sv(0,0,0,0), "R9 last refresh edge");
    step(K_ACT, 3, 0, 0, sv(1,0,0,0), "R9 window closed");
    step(K_LMR, 0, 0, 2, sv(1,0,0,0), "R8 mode load with open bank");
    step(K_NOP, 0, 0, 0, sv(2,0,0,0), "R2 activating ends");
    step(K_REF, 0, 0, 2, sv(2,0,0,0), "R8 refresh with open bank");
    step(K_PRE, 0, 1, 0, sv(7,0,0,0), "R13 precharge all");
    step(K_RD,  0, 0, 3, sv(7,0,0,0), "R9 read in precharge-all");
    step(K_NOP, 0, 0, 0, sv(0,0,0,0), "R13 precharge all ends");
    step(K_LMR, 0, 0, 0, sv(0,0,0,0), "R8 mode load");
    step(K_ACT, 2, 0, 3, sv(0,0,0,0), "R9 activate in mode window");
    step(K_ACT, 2, 0, 0, sv(0,1,0,0), "R2 activate bank2");
    step(K_PRE, 0, 1, 2, sv(0,1,0,0), "R13 precharge all while activating");
    step(K_NOP, 0, 0, 0, sv(0,2,0,0), "R12 state kept after error");
    step(K_WR,  2, 0, 0, sv(0,4,0,0), "R3 write");
    step(K_NOP, 0, 0, 0, sv(0,4,0,0), "R3 write holds");
    step(K_NOP, 0, 0, 0, sv(0,4,0,0), "R3 write holds");
    step(K_NOP, 0, 0, 0, sv(0,2,0,0), "R3 write ends");
    step(K_RD,  1, 0, 2, sv(0,2,0,0), "R7 read to idle bank");
    step(K_ACT, 2, 0, 2, sv(0,2,0,0), "R7 activate open bank");
    step(K_NOP, 0, 0, 0, sv(0,2,0,0), "R12 quiet after error");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule